// File: doc/BRIEF.md
# I2C Host Serial Clock Generator

This block produces the serial clock of an I2C host. A free-running prescaler turns the system clock into a tick: one tick every `baud + 1` clock cycles. A small slot sequencer then builds each SCL period out of a fixed number of ticks, and the 2-bit mode input selects that number: 5, 4 or 16. Within each period the sequencer lets go of the line and checks that the line really rose. If a client holds the line low (clock stretching), the sequencer keeps waiting. It then pulls the line low and checks that the line went low.

The block drives the line only through an open-drain pull-down enable. It reads the line back through a sampled input. Four one-cycle strobes mark the release, high-check, drive-low and low-check ticks. A level output shows when the block is held up by a stretching client. A sticky flag reports a line that stayed high while it should have been low. The baud value and the mode are captured only at a period boundary, so the current period always completes with the settings it started with.

Top module: `i2c_scl_gen`

## Requirements
- R1: With the block enabled, a tick occurs every `baud + 1` clock cycles. The four strobes are one-cycle pulses, at most one of them is high in any cycle, and each appears only on a tick.
- R2: Mode 0 without stretching: a period is 5 ticks. The order is release (tick 1), high-check (ticks 2 and 3), drive-low (tick 4) and low-check (tick 5).
- R3: Mode 1 without stretching: a period is 4 ticks. The order is release (tick 1), high-check (tick 2), drive-low (tick 3) and low-check (tick 4).
- R4: Mode 2 without stretching: a period is 16 ticks. Release is on tick 1, ticks 2 to 5 carry no strobe, high-check is on tick 6, drive-low on tick 7, and low-check on ticks 8 to 16.
- R5: Mode value 3 behaves exactly like mode 2.
- R6: A high-check tick that samples the line low makes the period longer, one tick at a time, until a high sample is seen. After that first high sample, the block needs further consecutive high samples before drive-low: 2 in mode 0, 1 in mode 1, 6 in mode 2. A low sample at any high-check restarts the count.
- R7: `stretch` rises on the cycle after a high-check tick that sampled the line low. It falls on the cycle after the next high-check tick that samples the line high.
- R8: A low-check tick that samples the line high sets `err`. `err` stays set while the block is enabled and clears when the block is disabled.
- R9: Changes to `baud` and `mode` are captured only at the last low-check tick of a period, or while the block is disabled. They never affect the period in progress, except for the spacing of the next period's first tick.
- R10: While `en` is low, no strobe fires and `scl_drive_low`, `stretch` and `err` are 0. After `en` rises, the first release tick comes `baud` cycles after the cycle in which `en` was first high, counting that cycle as 0.
- R11: `scl_drive_low` (1 pulls the line low) becomes 1 on the cycle after a drive-low tick. It becomes 0 on the cycle after a release tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Enables the generator; low holds it idle and cleared |
| baud | input | BAUD_W | Prescaler value; tick every baud+1 cycles |
| mode | input | 2 | Period form: 0 = 5 ticks, 1 = 4 ticks, 2 or 3 = 16 ticks |
| scl_in | input | 1 | Sampled SCL line level |
| scl_drive_low | output | 1 | Open-drain pull-down enable for SCL |
| rel_stb | output | 1 | Release tick strobe |
| hi_chk_stb | output | 1 | High-check tick strobe |
| drv_low_stb | output | 1 | Drive-low tick strobe |
| lo_chk_stb | output | 1 | Low-check tick strobe |
| stretch | output | 1 | Waiting for a stretching client to let SCL rise |
| err | output | 1 | Sticky: SCL seen high on a low-check tick |

## Verification
The sequencer is exercised in every mode, including the reserved value 3, across a range of baud values. Each period is checked for total length, for the tick index of the drive-low and for the number of high- and low-check strobes. Some periods add a client that holds the line low for one to four high-checks. This shows whether the first-high-plus-further-samples rule for each mode is followed, and whether the stretch output covers exactly the waiting checks. Mode and baud are changed just after a release to show that the period in progress keeps its old settings. A line stuck high exercises the sticky error flag, and a disable/enable cycle checks the cleared state and the delay to the first tick.

// File: rtl/i2c_scl_gen.sv
module i2c_scl_gen #(
  parameter int BAUD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [BAUD_W-1:0] baud,
  input  logic [1:0]        mode,
  input  logic              scl_in,
  output logic              scl_drive_low,
  output logic              rel_stb,
  output logic              hi_chk_stb,
  output logic              drv_low_stb,
  output logic              lo_chk_stb,
  output logic              stretch,
  output logic              err
);

  localparam int CW = 4;
  localparam logic [CW-1:0] WAIT_M2 = CW'(3);
  localparam logic [CW-1:0] LOW_M2  = CW'(8);

  typedef enum logic [2:0] {PH_REL, PH_WAIT, PH_HCHK, PH_DRV, PH_LCHK} ph_t;

  ph_t               ph;
  logic [BAUD_W-1:0] pcnt, baud_q;
  logic [1:0]        mode_q;
  logic [CW-1:0]     cnt, hcnt, need_hi;
  logic              stretched;

  wire tick      = en && (pcnt == baud_q);
  wire long_form = mode_q == 2'd2;
  wire [1:0] mode_n = (mode == 2'd3) ? 2'd2 : mode;

  assign rel_stb     = tick && ph == PH_REL;
  assign hi_chk_stb  = tick && ph == PH_HCHK;
  assign drv_low_stb = tick && ph == PH_DRV;
  assign lo_chk_stb  = tick && ph == PH_LCHK;

  always_comb begin
    case (mode_q)
      2'd0:    need_hi = stretched ? CW'(3) : CW'(2);
      2'd1:    need_hi = stretched ? CW'(2) : CW'(1);
      default: need_hi = stretched ? CW'(7) : CW'(1);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph            <= PH_REL;
      pcnt          <= '0;
      baud_q        <= '0;
      mode_q        <= '0;
      cnt           <= '0;
      hcnt          <= '0;
      stretched     <= 1'b0;
      stretch       <= 1'b0;
      err           <= 1'b0;
      scl_drive_low <= 1'b0;
    end else if (!en) begin
      ph            <= PH_REL;
      pcnt          <= '0;
      baud_q        <= baud;
      mode_q        <= mode_n;
      cnt           <= '0;
      hcnt          <= '0;
      stretched     <= 1'b0;
      stretch       <= 1'b0;
      err           <= 1'b0;
      scl_drive_low <= 1'b0;
    end else begin
      pcnt <= tick ? '0 : pcnt + 1'b1;
      if (tick) begin
        case (ph)
          PH_REL: begin
            scl_drive_low <= 1'b0;
            hcnt          <= '0;
            cnt           <= WAIT_M2;
            ph            <= long_form ? PH_WAIT : PH_HCHK;
          end
          PH_WAIT: begin
            if (cnt == '0) ph <= PH_HCHK;
            else           cnt <= cnt - 1'b1;
          end
          PH_HCHK: begin
            if (scl_in) begin
              stretch <= 1'b0;
              if (hcnt + 1'b1 >= need_hi) begin
                hcnt <= '0;
                ph   <= PH_DRV;
              end else begin
                hcnt <= hcnt + 1'b1;
              end
            end else begin
              stretch   <= 1'b1;
              stretched <= 1'b1;
              hcnt      <= '0;
            end
          end
          PH_DRV: begin
            scl_drive_low <= 1'b1;
            cnt           <= long_form ? LOW_M2 : '0;
            ph            <= PH_LCHK;
          end
          PH_LCHK: begin
            if (scl_in) err <= 1'b1;
            if (cnt == '0) begin
              ph        <= PH_REL;
              stretched <= 1'b0;
              baud_q    <= baud;
              mode_q    <= mode_n;
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
          default: ph <= PH_REL;
        endcase
      end
    end
  end

endmodule

// File: rtl/i2c_scl_gen_chk.sv
module i2c_scl_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic scl_in,
  input logic scl_drive_low,
  input logic rel_stb,
  input logic hi_chk_stb,
  input logic drv_low_stb,
  input logic lo_chk_stb,
  input logic stretch,
  input logic err
);

  assert_strobe_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rel_stb, hi_chk_stb, drv_low_stb, lo_chk_stb}));

  assert_drive_after_drv_R11: assert property (@(posedge clk) disable iff (!rst_n)
    drv_low_stb |=> scl_drive_low);

  assert_release_after_rel_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rel_stb |=> !scl_drive_low);

  assert_idle_outputs_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!scl_drive_low && !err && !stretch));

  assert_idle_no_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !(rel_stb || hi_chk_stb || drv_low_stb || lo_chk_stb));

  assert_err_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_chk_stb && scl_in) |=> err);

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (err && en) |=> err);

  assert_stretch_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stretch) |-> $past(hi_chk_stb && !scl_in));

endmodule

bind i2c_scl_gen i2c_scl_gen_chk u_chk (.*);

// File: tb/tb_i2c_scl_gen.sv
module tb_i2c_scl_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [7:0] baud = 8'd7;
  logic [1:0] mode = 2'd0;
  logic       hold = 1'b0;
  logic       stuck_hi = 1'b0;
  logic       scl_in;
  logic       scl_drive_low, rel_stb, hi_chk_stb, drv_low_stb, lo_chk_stb, stretch, err;
  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  assign scl_in = stuck_hi | (!scl_drive_low & !hold);

  i2c_scl_gen #(.BAUD_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .en(en), .baud(baud), .mode(mode), .scl_in(scl_in),
    .scl_drive_low(scl_drive_low), .rel_stb(rel_stb), .hi_chk_stb(hi_chk_stb),
    .drv_low_stb(drv_low_stb), .lo_chk_stb(lo_chk_stb), .stretch(stretch), .err(err)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic string mode_req(input int m);
    if (m == 3) return "R5";
    if (m == 2) return "R4";
    if (m == 1) return "R3";
    return "R2";
  endfunction

  // Starts at the negedge showing rel_stb, returns at the next one.
  // m/bo: settings of this period; bn: baud captured at its end; lows: client-held high-checks.
  task automatic run_period(input int m, input int bo, input int bn, input int lows, input bit exp_err);
    int mm     = (m == 3) ? 2 : m;
    int waits  = (mm == 2) ? 4 : 0;
    int further = (mm == 0) ? 2 : ((mm == 1) ? 1 : 6);
    int plain  = (mm == 0) ? 2 : 1;
    int hc     = (lows > 0) ? lows + 1 + further : plain;
    int lowt   = (mm == 2) ? 9 : 1;
    int didx_e = 2 + waits + hc;
    int ticks  = didx_e + lowt;
    int cyc_e  = (ticks - 1) * (bo + 1) + (bn + 1);
    int c = 0, nh = 0, nl = 0, didx = 0, seen = 0;
    bit pend = 0, sbad = 0;
    string rq = mode_req(m);
    hold = (lows > 0);
    do begin
      @(negedge clk);
      c++;
      if (pend) begin hold = 1'b0; pend = 0; end
      if (hi_chk_stb) begin
        nh++;
        if (hold) begin seen++; if (seen == lows) pend = 1; end
        if (nh >= 2 && nh <= lows + 1 && !stretch) sbad = 1;
      end
      if (drv_low_stb) didx = (c - 1) / (bo + 1) + 2;
      if (lo_chk_stb) nl++;
    end while (!rel_stb && c < 5000);
    hold = 1'b0;
    check(c == cyc_e, (lows > 0) ? "R6" : rq, "period cycles (R1 tick spacing)", c, cyc_e);
    check(nh == hc, (lows > 0) ? "R6" : rq, "high-check count", nh, hc);
    check(didx == didx_e, rq, "drive-low tick index", didx, didx_e);
    check(nl == lowt, rq, "low-check count", nl, lowt);
    if (lows > 0) check(!sbad, "R7", "stretch high during held checks", sbad, 0);
    check(stretch == 1'b0, "R7", "stretch low at period end", stretch, 0);
    check(err == exp_err, "R8", "error flag", err, exp_err);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int c;
    int cm, cb, nm, nb, ln;
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    check(scl_drive_low == 0 && rel_stb == 0 && stretch == 0 && err == 0, "R10", "reset outputs",
          {scl_drive_low, rel_stb, stretch, err}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R10: first release tick after enabling
    en = 1'b1; c = 0;
    while (!rel_stb && c < 1000) begin @(negedge clk); c++; end
    check(c == 7, "R10", "cycles to first release", c, 7);

    // R1, R2 directed: mode 0, baud 7 -> 40-cycle periods
    run_period(0, 7, 7, 0, 0);
    // R9: mode changed mid-period, current period keeps mode 0
    mode = 2'd1;
    run_period(0, 7, 7, 0, 0);
    run_period(1, 7, 7, 0, 0);              // R3
    run_period(1, 7, 7, 2, 0);              // R6 mode 1 stretch
    mode = 2'd2;
    run_period(1, 7, 7, 0, 0);
    run_period(2, 7, 7, 0, 0);              // R4
    run_period(2, 7, 7, 3, 0);              // R6 mode 2 stretch
    mode = 2'd3; baud = 8'd2;               // R9: baud changes at period end only
    run_period(2, 7, 2, 0, 0);
    run_period(3, 2, 2, 0, 0);              // R5
    mode = 2'd0;
    run_period(3, 2, 2, 1, 0);
    run_period(0, 2, 2, 1, 0);              // R6 mode 0 stretch
    baud = 8'd0;
    run_period(0, 2, 0, 0, 0);
    run_period(0, 0, 0, 4, 0);              // R1 boundary: tick every cycle

    // R8: line stuck high
    stuck_hi = 1'b1;
    run_period(0, 0, 0, 0, 1);
    stuck_hi = 1'b0;
    run_period(0, 0, 0, 0, 1);

    // R10: disable clears and silences
    en = 1'b0;
    @(negedge clk);
    check(scl_drive_low == 0 && err == 0 && stretch == 0, "R10", "disabled outputs",
          {scl_drive_low, err, stretch}, 0);
    c = 0;
    baud = 8'd3; mode = 2'd1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (rel_stb || hi_chk_stb || drv_low_stb || lo_chk_stb || scl_drive_low) c++;
    end
    check(c == 0, "R10", "activity while disabled", c, 0);
    en = 1'b1; c = 0;
    while (!rel_stb && c < 1000) begin @(negedge clk); c++; end
    check(c == 3, "R10", "cycles to first release after re-enable", c, 3);

    // Random stimulus: mode, baud and stretch length
    cm = 1; cb = 3;
    for (int it = 0; it < 40; it++) begin
      nm = int'($urandom % 4);
      nb = int'($urandom % 6);
      ln = ($urandom % 3 == 0) ? int'($urandom % 4) + 1 : 0;
      mode = nm[1:0]; baud = nb[7:0];
      run_period(cm, cb, nb, ln, 0);        // R9 settings taken at period end
      cm = nm; cb = nb;
    end

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule